// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple host port and the strobe pins of an asynchronous DRAM that stores 2M bytes. The host presents a 21-bit byte address, a write flag and write data under a valid/ready handshake. The controller multiplexes the address onto a 12-bit shared bus: the upper twelve bits form the row, sent with the row strobe, and the lower nine bits form the column, sent with the column strobe. Reads return one byte with a single-cycle valid pulse.

After an access the row stays open. A later request to the same row is served as a column-only page cycle. A request to another row closes the page and waits out the row precharge before the new row opens. The page also closes when the row has been open close to its maximum time, or when an external refresh engine asks for the bus. Writes use the early-write form: write enable and data are driven before the column strobe falls, and output enable stays high. Every delay is a cycle count held in a parameter. The defaults assume a 100 MHz clock and a 60 ns speed grade.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four strobes are high (inactive), the data drive enable and `rdata_valid` are low, `refresh_grant` is low, and `req_ready` is high while `refresh_req` is low.
- R2: The row address `req_addr[20:9]` is on `dram_addr` when `dram_ras_n` falls, at the edge that accepts the request. The column `req_addr[8:0]`, zero-extended to 12 bits, is on `dram_addr` when `dram_cas_n` falls, and the bus does not change on that edge.
- R3: A read returns `rdata` with a one-cycle `rdata_valid` pulse. The data is sampled from `dram_dq_in` on the first edge at least T_RAC cycles after the row strobe fell and at least T_CAC cycles after the column strobe fell. With the defaults this is 6 cycles after the accepting edge when the row was closed, and 3 cycles after it on a page hit.
- R4: A write drives `dram_we_n` low and puts the write data on `dram_dq_out`, with `dram_dq_oe` high, one cycle before `dram_cas_n` falls. Both stay until the column strobe rises. `dram_oe_n` stays high throughout.
- R5: A request to the open row is accepted while `dram_ras_n` is low and is served without raising the row strobe.
- R6: `dram_ras_n` is high for at least T_RP (4) cycles before every falling edge.
- R7: `dram_ras_n` stays low for at least T_RAS (6) cycles each time it falls.
- R8: `dram_cas_n` is low only while `dram_ras_n` is low. Each low pulse lasts at least T_CAS (2) cycles. Between two column cycles of one page it is high for at least T_CPN (2) cycles.
- R9: `refresh_grant` is given only when the row is closed and precharged. While it is high, both strobes are high and `req_ready` is low. A pending refresh closes an open page.
- R10: The row strobe never stays low for T_RASP (10000) cycles or more. An idle open page is closed T_GUARD cycles before that limit.
- R11: `dram_oe_n` goes low only during read column cycles. It is never low together with `dram_we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address, row in upper 12 bits |
| req_wdata | input | 8 | Write data |
| rdata_valid | output | 1 | One-cycle pulse with read data |
| rdata | output | 8 | Read data |
| refresh_req | input | 1 | External refresh engine wants the bus |
| refresh_grant | output | 1 | Bus handed to the refresh engine |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from memory |

## Verification
The row strobe falls on the same edge that accepts a request from a closed row. The column strobe falls two edges later, or one edge after acceptance on a page hit. Read data is due 6 cycles after acceptance from a closed row and 3 cycles after acceptance on a page hit. The bench records the accepting edge number, samples every output at the falling clock edge after each rising edge, and compares the `rdata_valid` cycle and the data against a queue filled from a behavioural byte array. A memory model in the bench returns a poison value when it is sampled earlier than the row and column access counts allow. Pulse widths and precharge gaps are measured by counting falling-edge samples between strobe transitions.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 8,
  parameter int T_RAH   = 1,
  parameter int T_CAS   = 2,
  parameter int T_CAC   = 2,
  parameter int T_OEA   = 2,
  parameter int T_RAC   = 6,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 4,
  parameter int T_CPN   = 2,
  parameter int T_RASP  = 10000,
  parameter int T_GUARD = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rdata_valid,
  output logic [DATA_W-1:0]       rdata,
  input  logic                    refresh_req,
  output logic                    refresh_grant,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [ROW_W-1:0]        dram_addr,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CNT_W  = $clog2(T_RASP + 1);
  localparam logic [CNT_W-1:0] C_RAH   = CNT_W'(T_RAH);
  localparam logic [CNT_W-1:0] C_CAS   = CNT_W'(T_CAS);
  localparam logic [CNT_W-1:0] C_CAC   = CNT_W'(T_CAC);
  localparam logic [CNT_W-1:0] C_OEA   = CNT_W'(T_OEA);
  localparam logic [CNT_W-1:0] C_RAC   = CNT_W'(T_RAC);
  localparam logic [CNT_W-1:0] C_RAS   = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] C_RP    = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] C_CPN   = CNT_W'(T_CPN);
  localparam logic [CNT_W-1:0] C_RASP  = CNT_W'(T_RASP);
  localparam logic [CNT_W-1:0] C_LIMIT = CNT_W'(T_RASP - T_GUARD);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_CASL, S_CPRE, S_OPEN, S_PRE, S_GRANT
  } state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt, ras_age;
  logic [ROW_W-1:0]   open_row;
  logic [COL_W-1:0]   col_q;
  logic               wr_q;
  logic [DATA_W-1:0]  wdata_q;

  logic [CNT_W-1:0]   lowcyc, ras_el;
  logic               hit, expire, close_now, cas_done;

  assign lowcyc    = cnt + 1'b1;
  assign ras_el    = ras_age + 1'b1;
  assign hit       = req_addr[ADDR_W-1:COL_W] == open_row;
  assign expire    = ras_age >= C_LIMIT;
  assign close_now = refresh_req || expire || (req_valid && !hit);
  assign cas_done  = (lowcyc >= C_CAS) &&
                     (wr_q || (lowcyc >= C_CAC && lowcyc >= C_OEA && ras_el >= C_RAC));

  assign req_ready     = (st == S_IDLE && !refresh_req) ||
                         (st == S_OPEN && !refresh_req && !expire && hit);
  assign refresh_grant = (st == S_GRANT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ras_age     <= '0;
      open_row    <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      cnt         <= lowcyc;
      if (!dram_ras_n && ras_age != C_RASP) ras_age <= ras_el;
      case (st)
        S_IDLE: begin
          if (refresh_req) begin
            st <= S_GRANT;
          end else if (req_valid) begin
            open_row   <= req_addr[ADDR_W-1:COL_W];
            col_q      <= req_addr[COL_W-1:0];
            wr_q       <= req_write;
            wdata_q    <= req_wdata;
            dram_addr  <= req_addr[ADDR_W-1:COL_W];
            dram_ras_n <= 1'b0;
            ras_age    <= '0;
            cnt        <= '0;
            st         <= S_ROW;
          end
        end
        S_ROW: begin
          if (lowcyc >= C_RAH) begin
            dram_addr   <= ROW_W'(col_q);
            dram_we_n   <= !wr_q;
            dram_dq_oe  <= wr_q;
            dram_dq_out <= wdata_q;
            st          <= S_COL;
          end
        end
        S_COL: begin
          dram_cas_n <= 1'b0;
          dram_oe_n  <= wr_q;
          cnt        <= '0;
          st         <= S_CASL;
        end
        S_CASL: begin
          if (cas_done) begin
            dram_cas_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!wr_q) begin
              rdata       <= dram_dq_in;
              rdata_valid <= 1'b1;
            end
            cnt <= '0;
            st  <= S_CPRE;
          end
        end
        S_CPRE: begin
          if (lowcyc >= C_CPN) st <= S_OPEN;
        end
        S_OPEN: begin
          if (close_now && ras_el >= C_RAS) begin
            dram_ras_n <= 1'b1;
            cnt        <= '0;
            st         <= S_PRE;
          end else if (req_valid && req_ready) begin
            col_q       <= req_addr[COL_W-1:0];
            wr_q        <= req_write;
            wdata_q     <= req_wdata;
            dram_addr   <= ROW_W'(req_addr[COL_W-1:0]);
            dram_we_n   <= !req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            st          <= S_COL;
          end
        end
        S_PRE: begin
          if (lowcyc >= C_RP) st <= S_IDLE;
        end
        S_GRANT: begin
          if (!refresh_req) begin
            cnt <= '0;
            st  <= S_PRE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] chk_hi;
  always_ff @(posedge clk) begin
    if (!rst_n)               chk_hi <= C_RP;
    else if (!dram_ras_n)     chk_hi <= '0;
    else if (chk_hi != C_RASP) chk_hi <= chk_hi + 1'b1;
  end

  // R6
  ras_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> chk_hi >= C_RP);
  // R7
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ras_age >= C_RAS);
  // R10
  ras_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> ras_age < C_RASP);
  // R8
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  // R2
  col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  // R4
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_we_n && dram_oe_n);
  // R11
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_oe_n && !dram_we_n));
  // R3
  rdata_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);
  // R9
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_grant |-> dram_ras_n && dram_cas_n && !req_ready);

endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rdata_valid, refresh_grant;
  logic [7:0] rdata;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [11:0] dram_addr;
  logic [7:0] dram_dq_out;
  logic [7:0] model_dq = 8'h00;

  always #5 clk = ~clk;

  fpm_dram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata_valid(rdata_valid), .rdata(rdata), .refresh_req(refresh_req),
    .refresh_grant(refresh_grant), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(model_dq)
  );

  int total = 0, fails = 0, cyc = 0;
  logic [7:0] mem [int];
  logic [7:0] refm [int];
  int q_data[$], q_acc[$], q_lat[$];
  logic [20:0] cur_addr = '0;
  logic cur_write = 1'b0;
  logic [7:0] cur_wdata = '0;
  bit hit_pending = 0, rose_in_hit = 0, page_cas = 0, done = 0;
  int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [11:0] m_row = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        chk(ras_hi >= 4, "R6 precharge", ras_hi, 4);
        chk(dram_addr == cur_addr[20:9], "R2 row", dram_addr, cur_addr[20:9]);
        m_row = dram_addr; ras_lo = 1; page_cas = 0;
      end else if (!prev_ras && dram_ras_n) begin
        chk(ras_lo >= 6, "R7 ras width", ras_lo, 6);
        chk(ras_lo < 10000, "R10 ras limit", ras_lo, 10000);
        if (hit_pending) rose_in_hit = 1;
        ras_hi = 1;
      end else if (dram_ras_n) ras_hi++;
      else ras_lo++;

      if (prev_cas && !dram_cas_n) begin
        if (page_cas) chk(cas_hi >= 2, "R8 cas precharge", cas_hi, 2);
        chk(!dram_ras_n, "R8 cas inside ras", dram_ras_n, 0);
        chk(dram_addr == {3'b000, cur_addr[8:0]}, "R2 column", dram_addr, cur_addr[8:0]);
        if (cur_write) begin
          chk(!prev_we && dram_dq_oe && dram_oe_n && dram_dq_out == cur_wdata,
              "R4 early write", {prev_we, dram_dq_oe, dram_oe_n, dram_dq_out}, {3'b011, cur_wdata});
          mem[{m_row, dram_addr[8:0]}] = dram_dq_out;
        end
        if (hit_pending) begin
          chk(!rose_in_hit, "R5 page hit keeps row", rose_in_hit, 0);
          hit_pending = 0; rose_in_hit = 0;
        end
        cas_lo = 1; page_cas = 1;
      end else if (!prev_cas && dram_cas_n) begin
        chk(cas_lo >= 2, "R8 cas width", cas_lo, 2);
        cas_hi = 1;
      end else if (dram_cas_n) cas_hi++;
      else cas_lo++;

      if (!dram_oe_n && !dram_we_n) chk(0, "R11 oe with we", 0, 1);
      if (!dram_oe_n && cur_write) chk(0, "R11 oe on write", 0, 1);

      if (!dram_oe_n && ras_lo >= 6 && cas_lo >= 2 && !dram_cas_n && !dram_ras_n)
        model_dq = mem.exists({m_row, dram_addr[8:0]}) ? mem[{m_row, dram_addr[8:0]}] : 8'h00;
      else
        model_dq = 8'hEE;

      if (rdata_valid) begin
        if (q_data.size() == 0) chk(0, "R3 unexpected rdata_valid", 1, 0);
        else begin
          int d, a, l;
          d = q_data.pop_front(); a = q_acc.pop_front(); l = q_lat.pop_front();
          chk(rdata == d[7:0], "R3 read data", rdata, d);
          chk(cyc - a == l, "R3 read latency", cyc - a, l);
        end
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
    end
  end

  task automatic do_req(input bit w, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (req_ready) begin
        bit page;
        page = !dram_ras_n;
        cur_addr = a; cur_write = w; cur_wdata = d;
        if (page) begin hit_pending = 1; rose_in_hit = 0; end
        if (w) refm[a] = d;
        else begin
          q_data.push_back(refm.exists(a) ? int'(refm[a]) : 0);
          q_acc.push_back(cyc + 1);
          q_lat.push_back(page ? 3 : 6);
        end
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    chk(!dram_dq_oe && !rdata_valid && !refresh_grant, "R1 idle outputs",
        {dram_dq_oe, rdata_valid, refresh_grant}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    do_req(1, 21'h12345, 8'h5A);
    do_req(1, 21'h12346, 8'hA5);
    do_req(0, 21'h12345, 8'h00);
    do_req(0, 21'h12346, 8'h00);
    do_req(0, 21'h0A001, 8'h00);
    do_req(1, 21'h0A002, 8'h3C);
    do_req(0, 21'h12346, 8'h00);
    do_req(0, 21'h0A002, 8'h00);
    for (int i = 0; i < 24; i++) begin
      logic [20:0] a;
      a = {(i % 3 == 0) ? 12'h091 : 12'h7FF, 9'(i % 5)};
      do_req((i % 4) < 2, a, 8'(i * 37 + 1));
    end

    // R9 refresh while a page is open
    do_req(0, 21'h12345, 8'h00);
    @(negedge clk);
    refresh_req = 1'b1;
    while (!refresh_grant) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && ras_hi >= 4, "R9 grant after precharge",
        {dram_ras_n, dram_cas_n}, 3);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 21'h12345;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk(!req_ready && refresh_grant && dram_ras_n, "R9 bus held",
          {req_ready, refresh_grant}, 1);
      @(negedge clk);
    end
    req_valid = 1'b0; refresh_req = 1'b0;
    do_req(0, 21'h12345, 8'h00);

    // R10 idle open page
    repeat (10100) @(negedge clk);
    chk(dram_ras_n, "R10 page closed", dram_ras_n, 1);
    do_req(0, 21'h0A002, 8'h00);

    repeat (30) @(negedge clk);
    chk(q_data.size() == 0, "R3 all reads returned", q_data.size(), 0);
    done = 1;
    report();
  end
endmodule